// File: doc/BRIEF.md
# Virtual-Channel ADC Conversion Scheduler

This block sits between a 32-bit register port and a pair of analog converter cores, called core A and core B. Software sees sixteen virtual channels. Each channel has a configuration word that can enable either core, or both, and picks one of eight inputs on each enabled core. To request a conversion, software writes a mask to a set alias of a shared request register. A fixed-priority arbiter then hands the converter to one pending channel at a time. When that channel's conversion ends, one 12-bit result is stored for each enabled core, and the channel's request bit drops on its own.

A clear alias of the request register lets software withdraw a request that is still waiting, or stop a conversion that is running. A power-down bit stops new conversions from starting without losing any pending request. A busy flag covers a running conversion and a fixed settling window after every power-state change. The analog cores are modelled by a deterministic stub whose value encodes the core, the selected input and the channel.

Top module: `vcadc_sched`

## Requirements
- R1: After reset, the request register, every configuration word, every result word, the power-down bit and the busy flag all read 0.
- R2: The request register reads at 0x030, with bit n for channel n. Writing a mask to 0x034 sets the request bits where the mask has ones and leaves the other bits unchanged.
- R3: Writing a mask to 0x038 clears the request bits where the mask has ones and leaves the other bits unchanged.
- R4: The configuration word of channel n is at 0x0C0+4n. Bit 15 enables core A and bits 2:0 select its input. Bit 16 enables core B and bits 5:3 select its input. All other bits read 0.
- R5: Channel 0 has the highest priority. A channel is granted only when the converter is idle, and a running conversion is never preempted by a higher-priority request.
- R6: A conversion lasts CONV_CYCLES (20) clocks. A lone request written at clock edge W is granted at edge W+1, and its request bit clears at edge W+CONV_CYCLES+1.
- R7: Results are at 0x100+4n for core A and at 0x140+4n for core B, in bits 11:0. The stub value is {core (0=A, 1=B), input[2:0], channel[3:0], 4'h5}. Only enabled cores update their result, and a channel with both cores enabled updates both.
- R8: A granted channel with neither core enabled clears its request bit at the grant edge and changes no result.
- R9: Clearing a request bit before the channel is granted cancels the request, and no result changes.
- R10: Clearing the request bit of the running channel aborts the conversion. No result changes and the converter becomes free again.
- R11: Bit 3 at 0x040 is power-down and reads back. While it is set, no conversion starts and pending request bits are held. Each change of the bit makes busy read 1 for PWR_CYCLES (8) clocks, and no conversion starts during that window.
- R12: Bit 6 at 0x02C reads 1 while a conversion runs or a power settling window is open, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_addr | input | 12 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
On every cycle the assertions check the following: a conversion starts only for the lowest-numbered pending channel, a running conversion keeps its channel until it ends or is aborted, nothing starts while power-down is set, and a finished channel's request bit drops. The exact completion edge, the stub values stored per core, the effect of cancelling or aborting, and the busy window after a power change all involve stored data and timing across several operations. Only the bench scenarios can show these, by reading the registers back.

// File: rtl/vcadc_pkg.sv
package vcadc_pkg;
    localparam int NUM_VC = 16;
    localparam int VC_W   = $clog2(NUM_VC);
    localparam int RES_W  = 12;
    localparam int SEL_W  = 3;

    localparam logic [11:0] ADR_CTRL = 12'h02C;
    localparam logic [11:0] ADR_REQ  = 12'h030;
    localparam logic [11:0] ADR_RSET = 12'h034;
    localparam logic [11:0] ADR_RCLR = 12'h038;
    localparam logic [11:0] ADR_PWR  = 12'h040;
    localparam logic [5:0]  PG_CFG   = 6'h03;
    localparam logic [5:0]  PG_RES_A = 6'h04;
    localparam logic [5:0]  PG_RES_B = 6'h05;
    localparam int BUSY_BIT = 6;
    localparam int PD_BIT   = 3;
    localparam int EN_A_BIT = 15;
    localparam int EN_B_BIT = 16;

    typedef struct packed {
        logic             en_b;
        logic             en_a;
        logic [SEL_W-1:0] sel_b;
        logic [SEL_W-1:0] sel_a;
    } vc_cfg_t;

    typedef struct packed {
        logic             wr_a;
        logic             wr_b;
        logic [VC_W-1:0]  vc;
        logic [RES_W-1:0] val_a;
        logic [RES_W-1:0] val_b;
    } result_t;

    function automatic logic [RES_W-1:0] stub_sample(logic core, logic [SEL_W-1:0] sel,
                                                     logic [VC_W-1:0] vc);
        return {core, sel, vc, 4'h5};
    endfunction

    function automatic vc_cfg_t word_to_cfg(logic [31:0] w);
        vc_cfg_t c;
        c.en_b  = w[EN_B_BIT];
        c.en_a  = w[EN_A_BIT];
        c.sel_b = w[5:3];
        c.sel_a = w[2:0];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(vc_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[EN_B_BIT] = c.en_b;
        w[EN_A_BIT] = c.en_a;
        w[5:3]      = c.sel_b;
        w[2:0]      = c.sel_a;
        return w;
    endfunction
endpackage

// File: rtl/vcadc_arbiter.sv
module vcadc_arbiter
    import vcadc_pkg::*;
#(
    parameter int N = NUM_VC,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          grant_valid,
    output logic [IW-1:0] grant_idx
);
    always_comb begin
        grant_valid = |req;
        grant_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) grant_idx = IW'(i);
        end
    end
endmodule

// File: rtl/vcadc_engine.sv
module vcadc_engine
    import vcadc_pkg::*;
#(
    parameter int CONV_CYCLES = 20,
    parameter int PWR_CYCLES  = 8,
    localparam int CNT_W = $clog2(CONV_CYCLES),
    localparam int PWR_W = $clog2(PWR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_VC-1:0] req_q,
    input  logic              grant_valid,
    input  logic [VC_W-1:0]   grant_idx,
    input  vc_cfg_t           grant_cfg,
    input  logic              pd,
    input  logic              pd_change,
    output logic [NUM_VC-1:0] done_mask,
    output result_t           res,
    output logic              conv_active,
    output logic [VC_W-1:0]   active_vc,
    output logic              cnt_zero,
    output logic              busy
);
    vc_cfg_t          cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PWR_W-1:0] pwr_q;
    logic             can_start, no_core;

    assign cnt_zero  = (cnt_q == '0);
    assign can_start = !conv_active && !pd && (pwr_q == '0) && grant_valid;
    assign no_core   = !grant_cfg.en_a && !grant_cfg.en_b;
    assign busy      = conv_active || (pwr_q != '0);

    always_comb begin
        done_mask = '0;
        res       = '0;
        res.vc    = active_vc;
        res.val_a = stub_sample(1'b0, cfg_q.sel_a, active_vc);
        res.val_b = stub_sample(1'b1, cfg_q.sel_b, active_vc);
        if (can_start && no_core) done_mask[grant_idx] = 1'b1;
        if (conv_active && req_q[active_vc] && cnt_zero) begin
            done_mask[active_vc] = 1'b1;
            res.wr_a = cfg_q.en_a;
            res.wr_b = cfg_q.en_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_active <= 1'b0;
            active_vc   <= '0;
            cfg_q       <= '0;
            cnt_q       <= '0;
            pwr_q       <= '0;
        end else begin
            if (pd_change)        pwr_q <= PWR_W'(PWR_CYCLES);
            else if (pwr_q != '0) pwr_q <= pwr_q - 1'b1;

            if (conv_active) begin
                if (!req_q[active_vc] || cnt_zero) conv_active <= 1'b0;
                else                               cnt_q <= cnt_q - 1'b1;
            end else if (can_start && !no_core) begin
                conv_active <= 1'b1;
                active_vc   <= grant_idx;
                cfg_q       <= grant_cfg;
                cnt_q       <= CNT_W'(CONV_CYCLES - 1);
            end
        end
    end
endmodule

// File: rtl/vcadc_sched.sv
module vcadc_sched
    import vcadc_pkg::*;
#(
    parameter int CONV_CYCLES = 20,
    parameter int PWR_CYCLES  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic [NUM_VC-1:0] req_q, set_mask, clr_mask, done_mask;
    vc_cfg_t           cfg_q [NUM_VC];
    logic [RES_W-1:0]  res_a_q [NUM_VC];
    logic [RES_W-1:0]  res_b_q [NUM_VC];
    logic              pd_q, pd_change, grant_valid, conv_active, cnt_zero, busy;
    logic [VC_W-1:0]   grant_idx, active_vc, word_idx;
    result_t           res;

    assign word_idx  = bus_addr[VC_W+1:2];
    assign set_mask  = (bus_wr && bus_addr == ADR_RSET) ? bus_wdata[NUM_VC-1:0] : '0;
    assign clr_mask  = (bus_wr && bus_addr == ADR_RCLR) ? bus_wdata[NUM_VC-1:0] : '0;
    assign pd_change = bus_wr && (bus_addr == ADR_PWR) && (bus_wdata[PD_BIT] != pd_q);

    vcadc_arbiter #(.N(NUM_VC)) u_arb (
        .req         (req_q),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    vcadc_engine #(.CONV_CYCLES(CONV_CYCLES), .PWR_CYCLES(PWR_CYCLES)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .req_q       (req_q),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_cfg   (cfg_q[grant_idx]),
        .pd          (pd_q),
        .pd_change   (pd_change),
        .done_mask   (done_mask),
        .res         (res),
        .conv_active (conv_active),
        .active_vc   (active_vc),
        .cnt_zero    (cnt_zero),
        .busy        (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pd_q  <= 1'b0;
        end else begin
            req_q <= ((req_q & ~done_mask) | set_mask) & ~clr_mask;
            if (bus_wr && bus_addr == ADR_PWR) pd_q <= bus_wdata[PD_BIT];
        end
    end

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g]   <= '0;
                res_a_q[g] <= '0;
                res_b_q[g] <= '0;
            end else begin
                if (bus_wr && bus_addr[11:6] == PG_CFG && word_idx == VC_W'(g))
                    cfg_q[g] <= word_to_cfg(bus_wdata);
                if (res.wr_a && res.vc == VC_W'(g)) res_a_q[g] <= res.val_a;
                if (res.wr_b && res.vc == VC_W'(g)) res_b_q[g] <= res.val_b;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr[11:6])
            PG_CFG:   bus_rdata = cfg_to_word(cfg_q[word_idx]);
            PG_RES_A: bus_rdata = 32'(res_a_q[word_idx]);
            PG_RES_B: bus_rdata = 32'(res_b_q[word_idx]);
            default: begin
                if (bus_addr == ADR_REQ)  bus_rdata = 32'(req_q);
                if (bus_addr == ADR_CTRL) bus_rdata[BUSY_BIT] = busy;
                if (bus_addr == ADR_PWR)  bus_rdata[PD_BIT] = pd_q;
            end
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[31:17], bus_wdata[14:6], bus_addr[1:0], conv_active, cnt_zero};
endmodule

// File: rtl/vcadc_checker.sv
module vcadc_checker
    import vcadc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NUM_VC-1:0] req_q,
    input logic [NUM_VC-1:0] set_mask,
    input logic              conv_active,
    input logic [VC_W-1:0]   active_vc,
    input logic              cnt_zero,
    input logic              pd_q
);
    logic [NUM_VC-1:0] lower_mask;
    assign lower_mask = (NUM_VC'(1) << active_vc) - NUM_VC'(1);

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_active) |-> (($past(req_q) & lower_mask) == '0)); // R5

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (conv_active && !cnt_zero && req_q[active_vc]) |=> (conv_active && $stable(active_vc))); // R5

    AST_PWRDN_NO_START: assert property (@(posedge clk) disable iff (rst)
        (pd_q && !conv_active) |=> !conv_active); // R11

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (conv_active && cnt_zero && req_q[active_vc] && set_mask == '0)
            |=> !req_q[$past(active_vc)]); // R6
endmodule

bind vcadc_sched vcadc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_q       (req_q),
    .set_mask    (set_mask),
    .conv_active (conv_active),
    .active_vc   (active_vc),
    .cnt_zero    (cnt_zero),
    .pd_q        (pd_q)
);

// File: tb/tb_vcadc_sched.sv
module tb_vcadc_sched;
    localparam int CONV = 20;
    localparam int PWR  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [11:0] addr;
        logic [31:0] mask;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    vcadc_sched #(.CONV_CYCLES(CONV), .PWR_CYCLES(PWR)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] stub(logic core, logic [2:0] sel, logic [3:0] vc);
        return 32'({core, sel, vc, 4'h5});
    endfunction

    function automatic logic [31:0] cfgw(logic ea, logic [2:0] sa, logic eb, logic [2:0] sb);
        return (32'(eb) << 16) | (32'(ea) << 15) | (32'(sb) << 3) | 32'(sa);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: queue an expected register value
    task automatic expect_reg(input logic [11:0] a, input logic [31:0] m,
                              input logic [31:0] e, input string tag);
        exp_item_t it;
        it.addr = a; it.mask = m; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor side: pop each expectation and compare with the live register
    task automatic monitor_drain();
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [31:0] got;
            it = sb_q.pop_front();
            bus_addr = it.addr;
            #1;
            got = bus_rdata & it.mask;
            checks++;
            if (got !== (it.exp & it.mask)) begin
                errors++;
                $display("FAIL %s addr=%03h actual=%08h expected=%08h",
                         it.tag, it.addr, got, it.exp & it.mask);
            end
        end
    endtask

    localparam logic [31:0] ALL  = 32'hFFFF_FFFF;
    localparam logic [31:0] BUSY = 32'h40;

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        expect_reg(12'h030, ALL, 0, "R1 request");
        expect_reg(12'h02C, ALL, 0, "R1 busy");
        expect_reg(12'h0C0, ALL, 0, "R1 cfg0");
        expect_reg(12'h100, ALL, 0, "R1 resA0");
        expect_reg(12'h040, ALL, 0, "R1 pwr");
        monitor_drain();

        // R4 configuration layout, stray bits dropped
        wr(12'h0CC, 32'h8000_0000 | cfgw(1, 3'd5, 1, 3'd2));
        expect_reg(12'h0CC, ALL, cfgw(1, 3'd5, 1, 3'd2), "R4 cfg3 readback");
        wr(12'h0C0, cfgw(1, 3'd1, 0, 3'd0));
        wr(12'h0C4, cfgw(0, 3'd0, 1, 3'd7));
        monitor_drain();

        // R2 R5 R6 R12: two requests in one write, VC0 first
        wr(12'h034, 32'h3);
        wait_cyc(CONV);
        expect_reg(12'h030, ALL, 32'h3, "R6 still pending at W+20");
        expect_reg(12'h02C, ALL, BUSY, "R12 busy during conversion");
        monitor_drain();
        wait_cyc(1);
        expect_reg(12'h030, ALL, 32'h2, "R5 VC0 done first, VC1 waits");
        monitor_drain();
        wait_cyc(CONV + 3);
        expect_reg(12'h030, ALL, 0, "R2 all requests served");
        expect_reg(12'h02C, ALL, 0, "R12 idle not busy");
        expect_reg(12'h100, ALL, stub(0, 3'd1, 4'd0), "R7 resA0");
        expect_reg(12'h140, ALL, 0, "R7 resB0 untouched");
        expect_reg(12'h144, ALL, stub(1, 3'd7, 4'd1), "R7 resB1");
        expect_reg(12'h104, ALL, 0, "R7 resA1 untouched");
        monitor_drain();

        // R7 dual-core channel
        wr(12'h034, 32'h8);
        wait_cyc(CONV + 3);
        expect_reg(12'h10C, ALL, stub(0, 3'd5, 4'd3), "R7 dual resA3");
        expect_reg(12'h14C, ALL, stub(1, 3'd2, 4'd3), "R7 dual resB3");
        monitor_drain();

        // R8 channel with no core enabled
        wr(12'h034, 32'h80);
        wait_cyc(1);
        expect_reg(12'h030, ALL, 0, "R8 empty cfg clears at once");
        expect_reg(12'h11C, ALL, 0, "R8 resA7 untouched");
        expect_reg(12'h15C, ALL, 0, "R8 resB7 untouched");
        monitor_drain();

        // R3 R9 cancel a waiting request
        wr(12'h0D4, cfgw(1, 3'd3, 0, 3'd0));
        wr(12'h034, 32'h21);
        wait_cyc(2);
        wr(12'h038, 32'h20);
        expect_reg(12'h030, ALL, 32'h1, "R3 clear only masked bit");
        monitor_drain();
        wait_cyc(2 * CONV + 5);
        expect_reg(12'h114, ALL, 0, "R9 cancelled VC5 no result");
        expect_reg(12'h030, ALL, 0, "R9 nothing pending");
        monitor_drain();

        // R10 abort a running conversion
        wr(12'h0C8, cfgw(1, 3'd6, 0, 3'd0));
        wr(12'h034, 32'h4);
        wait_cyc(5);
        wr(12'h038, 32'h4);
        wait_cyc(1);
        expect_reg(12'h02C, ALL, 0, "R10 converter freed");
        monitor_drain();
        wait_cyc(CONV + 3);
        expect_reg(12'h108, ALL, 0, "R10 aborted no result");
        monitor_drain();
        wr(12'h034, 32'h4);
        wait_cyc(CONV + 3);
        expect_reg(12'h108, ALL, stub(0, 3'd6, 4'd2), "R10 later rerun converts");
        monitor_drain();

        // R11 power-down holds requests
        wr(12'h0C0, cfgw(1, 3'd4, 0, 3'd0));
        wr(12'h040, 32'h8);
        expect_reg(12'h040, ALL, 32'h8, "R11 pd readback");
        expect_reg(12'h02C, ALL, BUSY, "R11 busy after pd change");
        monitor_drain();
        wait_cyc(PWR + 2);
        expect_reg(12'h02C, ALL, 0, "R11 busy window ends");
        monitor_drain();
        wr(12'h034, 32'h1);
        wait_cyc(2 * CONV);
        expect_reg(12'h030, ALL, 32'h1, "R11 request held");
        expect_reg(12'h100, ALL, stub(0, 3'd1, 4'd0), "R11 no conversion while down");
        monitor_drain();
        wr(12'h040, 32'h0);
        wait_cyc(PWR - 2);
        expect_reg(12'h030, ALL, 32'h1, "R11 no start in settle window");
        monitor_drain();
        wait_cyc(CONV + 6);
        expect_reg(12'h030, ALL, 0, "R11 resumes after power-up");
        expect_reg(12'h100, ALL, stub(0, 3'd4, 4'd0), "R11 result after power-up");
        monitor_drain();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule